// File: doc/BRIEF.md
# Timer Capture Channel Front End

This block is the pin-side logic of one timer channel. A direction field either turns the channel into an output stage or makes it an input stage. As an input stage it listens to one of three sources: the channel's own pin, the neighbouring channel's pin, or an internal trigger line. Each source is synchronised on its own path. The selected source then passes through an active-edge selector and an edge prescaler. When the prescaler fires, the value of an external free-running counter is latched into a capture register and a one-cycle strobe is raised. As an output stage the channel takes a reference waveform, applies polarity inversion and an enable gate, and drives the pin. All configuration arrives on plain input ports.

A small controller registers the configuration once per clock into one of four named states. ST_OFF is entered whenever the enable is 0. ST_DRIVE is entered for an enabled channel with direction 00. ST_SENSE is entered for an enabled input channel with a usable source and a usable edge selection. ST_HOLD is entered for an enabled input channel whose edge selection is the reserved code, or whose direction is 11 while the internal trigger is not chosen. The controller re-evaluates its state from the configuration on every clock, so any state can move to any other in one cycle. The transitions are named by their target: T_DISABLE into ST_OFF, T_TO_DRIVE, T_TO_SENSE and T_TO_HOLD. Outputs are decoded from the state: ST_OFF clears the prescaler, ST_DRIVE opens the output path, ST_SENSE opens the capture path, and ST_HOLD opens neither.

Top module: `cap_channel_fe`

## Requirements
- R1: Direction codes in `cfg_dir` route the input as follows: 01 uses `pin_own`, 10 uses `pin_nbr`, and 11 uses `trig_in`. Code 00 is output mode and produces no captures.
- R2: Two cases produce no captures at all: edge-selection code 10, and direction 11 while `trig_sel_ok` is 0.
- R3: Prescale code `cfg_psc` = p gives one capture for every 2^p qualified edges. The codes therefore mean every edge, every 2nd, every 4th and every 8th edge.
- R4: The prescale edge count is cleared while the channel is disabled. A change of `cfg_psc` on an enabled channel does not clear the count. The new ratio applies from the next edge, and that edge fires if the count already reaches the new limit.
- R5: Edge-selection code 00 qualifies rising edges, 01 qualifies falling edges, and 11 qualifies both edges of the selected source.
- R6: Timing of a capture is as follows. A source level first sampled at clock edge k is detected by clock edge k+2. At that edge `cap_val` loads the `cnt_val` present at edge k+2, and `cap_stb` is high for exactly that one cycle. A configuration sampled at edge j governs detections from edge j+1 onwards.
- R7: Each capture sets `cap_flag`. A capture while `cap_flag` is already set also sets `ovr_flag`. A `flag_clr` pulse clears both flags. If a capture and a clear occur in the same cycle, `cap_flag` ends set and `ovr_flag` ends clear.
- R8: When the registered configuration is enabled with direction 00, `pin_out` equals `ref_wave` XOR `cfg_edge[0]`, combinationally in `ref_wave`. In every other case `pin_out` is 0.
- R9: In ST_SENSE, `ch_trig` is the synchronised level of the selected source. It is inverted when the edge code is 01 and passed straight through otherwise. Outside ST_SENSE it is 0.
- R10: With `cfg_en` at 0 no capture is produced, whatever the source activity.
- R11: During reset `cap_stb`, `cap_flag`, `ovr_flag`, `cap_val`, `pin_out` and `ch_trig` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Channel enable |
| cfg_dir | input | 2 | Direction and source select |
| cfg_edge | input | 2 | Edge select (input) / bit 0 output polarity |
| cfg_psc | input | 2 | Capture prescale code |
| trig_sel_ok | input | 1 | Internal trigger is chosen as channel source |
| pin_own | input | 1 | This channel's raw pin |
| pin_nbr | input | 1 | Neighbouring channel's raw pin |
| trig_in | input | 1 | Internal trigger line |
| ref_wave | input | 1 | Reference waveform for output mode |
| cnt_val | input | CNT_W | Free-running counter value |
| flag_clr | input | 1 | Clear pulse for both flags |
| pin_out | output | 1 | Driven pin level |
| ch_trig | output | 1 | Conditioned input level for trigger use |
| cap_stb | output | 1 | One-cycle capture strobe |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| ovr_flag | output | 1 | Sticky overcapture flag |

## Verification
A source change sampled at clock edge k produces its capture strobe, its captured value and its flag update in the cycle after edge k+2. A configuration change is felt one edge later than the edge that samples it. The `pin_out` response to `ref_wave` is immediate, and `ch_trig` follows the level sampled one edge earlier. The bench model keeps a three-deep history of sampled source levels and the configuration of the previous edge, so it produces each of these results at exactly the edge where it is due. Every output is compared 3 ns after each rising edge, well away from the negative edge at which stimulus changes. Directed sequences additionally count strobes after a settling gap longer than the pipeline.

// File: rtl/cap_fe_pkg.sv
package cap_fe_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_DRIVE = 2'd1,
        ST_SENSE = 2'd2,
        ST_HOLD  = 2'd3
    } fe_state_e;

    localparam logic [1:0] DIR_DRIVE = 2'b00;
    localparam logic [1:0] DIR_OWN   = 2'b01;
    localparam logic [1:0] DIR_NBR   = 2'b10;
    localparam logic [1:0] DIR_TRIG  = 2'b11;

    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;
    localparam logic [1:0] EDGE_RSVD = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    localparam int NSRC = 3;

    typedef struct packed {
        logic       en;
        logic [1:0] dir;
        logic [1:0] edge_sel;
        logic [1:0] psc;
        logic       trig_ok;
    } fe_cfg_t;

endpackage

// File: rtl/cap_fe_sync.sv
module cap_fe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    localparam int LAST = STAGES;

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [LAST:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[LAST-1:0], raw[g]};
            end
        end

        assign lvl[g]  = chain[LAST-1];
        assign rise[g] = chain[LAST-1] & ~chain[LAST];
        assign fall[g] = ~chain[LAST-1] & chain[LAST];

        // R5: a level change yields a single-cycle edge pulse
        a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
        a_r5_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]);
    end

endmodule

// File: rtl/cap_fe_prescale.sv
module cap_fe_prescale #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          hit,
    input  logic [PW-1:0] psc,
    output logic          fire
);

    localparam int CW = (1 << PW) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'((32'd1 << psc) - 32'd1);
    assign fire = hit && !clr && (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (hit) begin
            if (fire) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: count is empty one cycle after a clear request
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R3: a firing edge restarts the count
    a_r3_fire_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt == '0));

endmodule

// File: rtl/cap_fe_ctrl.sv
module cap_fe_ctrl
    import cap_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fe_cfg_t   cfg,
    output fe_cfg_t   cfg_q,
    output fe_state_e state,
    output logic      drive,
    output logic      sense,
    output logic      clr
);

    fe_state_e nxt;

    always_comb begin
        if (!cfg.en) begin
            nxt = ST_OFF;
        end else if (cfg.dir == DIR_DRIVE) begin
            nxt = ST_DRIVE;
        end else if ((cfg.edge_sel == EDGE_RSVD) ||
                     ((cfg.dir == DIR_TRIG) && !cfg.trig_ok)) begin
            nxt = ST_HOLD;
        end else begin
            nxt = ST_SENSE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cfg_q <= '0;
        end else begin
            state <= nxt;
            cfg_q <= cfg;
        end
    end

    always_comb begin
        drive = 1'b0;
        sense = 1'b0;
        clr   = 1'b0;
        unique case (state)
            ST_OFF:   clr   = 1'b1;
            ST_DRIVE: drive = 1'b1;
            ST_SENSE: sense = 1'b1;
            ST_HOLD:  ;
        endcase
    end

    // R10: a disabled configuration always lands in ST_OFF
    a_r10_off_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (state == ST_OFF));

endmodule

// File: rtl/cap_channel_fe.sv
module cap_channel_fe
    import cap_fe_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_dir,
    input  logic [1:0]       cfg_edge,
    input  logic [1:0]       cfg_psc,
    input  logic             trig_sel_ok,
    input  logic             pin_own,
    input  logic             pin_nbr,
    input  logic             trig_in,
    input  logic             ref_wave,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic             pin_out,
    output logic             ch_trig,
    output logic             cap_stb,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);

    fe_cfg_t   cfg_in;
    fe_cfg_t   cfg_q;
    fe_state_e state;
    logic      drive;
    logic      sense;
    logic      clr;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] fall;

    logic sel_lvl;
    logic sel_rise;
    logic sel_fall;
    logic hit;
    logic fire;

    assign cfg_in = '{en: cfg_en, dir: cfg_dir, edge_sel: cfg_edge,
                      psc: cfg_psc, trig_ok: trig_sel_ok};
    assign raw    = {trig_in, pin_nbr, pin_own};

    cap_fe_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg_in),
        .cfg_q (cfg_q),
        .state (state),
        .drive (drive),
        .sense (sense),
        .clr   (clr)
    );

    cap_fe_sync #(.N(NSRC), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    always_comb begin
        case (cfg_q.dir)
            DIR_NBR: begin
                sel_lvl  = lvl[1];
                sel_rise = rise[1];
                sel_fall = fall[1];
            end
            DIR_TRIG: begin
                sel_lvl  = lvl[2];
                sel_rise = rise[2];
                sel_fall = fall[2];
            end
            default: begin
                sel_lvl  = lvl[0];
                sel_rise = rise[0];
                sel_fall = fall[0];
            end
        endcase
    end

    always_comb begin
        hit = 1'b0;
        if (sense) begin
            case (cfg_q.edge_sel)
                EDGE_RISE: hit = sel_rise;
                EDGE_FALL: hit = sel_fall;
                EDGE_BOTH: hit = sel_rise | sel_fall;
                default:   hit = 1'b0;
            endcase
        end
    end

    cap_fe_prescale #(.PW(2)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (hit),
        .psc   (cfg_q.psc),
        .fire  (fire)
    );

    assign pin_out = drive & (ref_wave ^ cfg_q.edge_sel[0]);
    assign ch_trig = sense & (sel_lvl ^ (cfg_q.edge_sel == EDGE_FALL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_stb  <= 1'b0;
            cap_val  <= '0;
            cap_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            cap_stb  <= fire;
            if (fire) begin
                cap_val <= cnt_val;
            end
            cap_flag <= fire | (cap_flag & ~flag_clr);
            ovr_flag <= (ovr_flag & ~flag_clr) | (fire & cap_flag & ~flag_clr);
        end
    end

    // R7: a strobe always comes with the capture flag set
    a_r7_flag_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> cap_flag);
    // R7: overcapture rises only on a strobe over an already set flag
    a_r7_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> (cap_stb && $past(cap_flag)));
    // R2: a held channel produces no strobe
    a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> !cap_stb);
    // R8: a disabled channel drives 0
    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_en) |-> !pin_out);
    // R10: no strobe two edges after a disabled configuration
    a_r10_off_no_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_en, 2) |-> !cap_stb);

endmodule

// File: tb/test_cap_channel_fe.sv
module test_cap_channel_fe;

    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic [1:0] cfg_dir = 2'b00;
    logic [1:0] cfg_edge = 2'b00;
    logic [1:0] cfg_psc = 2'b00;
    logic trig_sel_ok = 1'b0;
    logic pin_own = 1'b0;
    logic pin_nbr = 1'b0;
    logic trig_in = 1'b0;
    logic ref_wave = 1'b0;
    logic [CW-1:0] cnt_val = '0;
    logic flag_clr = 1'b0;
    logic pin_out, ch_trig, cap_stb, cap_flag, ovr_flag;
    logic [CW-1:0] cap_val;

    always #5 clk = ~clk;

    cap_channel_fe #(.CNT_W(CW)) i_cap_channel_fe (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
        .cfg_edge(cfg_edge), .cfg_psc(cfg_psc), .trig_sel_ok(trig_sel_ok),
        .pin_own(pin_own), .pin_nbr(pin_nbr), .trig_in(trig_in),
        .ref_wave(ref_wave), .cnt_val(cnt_val), .flag_clr(flag_clr),
        .pin_out(pin_out), .ch_trig(ch_trig), .cap_stb(cap_stb),
        .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
    );

    int total = 0;
    int bad = 0;
    int stb_seen = 0;
    bit done = 0;
    bit chk_on = 0;
    string tag = "R11 reset";

    // behavioural model state
    logic [2:0] h1, h2, h3;
    logic m_en, m_tok;
    logic [1:0] m_dir, m_edge, m_psc;
    int pcnt;
    logic e_stb, e_flag, e_ovr;
    logic [CW-1:0] e_val;

    function automatic int src_of(logic [1:0] d);
        return (d == 2'b10) ? 1 : (d == 2'b11) ? 2 : 0;
    endfunction

    function automatic bit m_sensing();
        return m_en && (m_dir != 2'b00) && (m_edge != 2'b10) &&
               !((m_dir == 2'b11) && !m_tok);
    endfunction

    task automatic check(string fld, logic [CW-1:0] got, logic [CW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s / %s: got %0h expected %0h at %0t", tag, fld, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit r, f, q, fire;
        int s;
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_en = 0; m_tok = 0; m_dir = 0; m_edge = 0; m_psc = 0;
            pcnt = 0; e_stb = 0; e_flag = 0; e_ovr = 0; e_val = 0;
        end else begin
            s = src_of(m_dir);
            r = h2[s] && !h3[s];
            f = !h2[s] && h3[s];
            q = m_sensing() && ((m_edge == 2'b00) ? r :
                                (m_edge == 2'b01) ? f : (r || f));
            fire = 0;
            if (!m_en) pcnt = 0;
            else if (q) begin
                if (pcnt >= (1 << m_psc) - 1) begin fire = 1; pcnt = 0; end
                else pcnt++;
            end
            e_ovr  = (e_ovr && !flag_clr) || (fire && e_flag && !flag_clr);
            e_flag = fire || (e_flag && !flag_clr);
            e_stb  = fire;
            if (fire) e_val = cnt_val;
            h3 = h2; h2 = h1; h1 = {trig_in, pin_nbr, pin_own};
            m_en = cfg_en; m_dir = cfg_dir; m_edge = cfg_edge;
            m_psc = cfg_psc; m_tok = trig_sel_ok;
        end
        #3;
        if (chk_on && !done) begin
            if (cap_stb) stb_seen++;
            check("R6 cap_stb", CW'(cap_stb), CW'(e_stb));
            check("R6 cap_val", cap_val, e_val);
            check("R7 cap_flag", CW'(cap_flag), CW'(e_flag));
            check("R7 ovr_flag", CW'(ovr_flag), CW'(e_ovr));
            check("R8 pin_out", CW'(pin_out),
                  CW'((m_en && m_dir == 2'b00) ? (ref_wave ^ m_edge[0]) : 1'b0));
            check("R9 ch_trig", CW'(ch_trig),
                  CW'(m_sensing() ? (h2[src_of(m_dir)] ^ (m_edge == 2'b01)) : 1'b0));
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    task automatic run(string t, int cycles, logic [2:0] mask, bit rnd_ref, bit rnd_clr);
        tag = t;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cnt_val = cnt_val + 1'b1;
            if (mask[0] && lfsr[1]) pin_own = ~pin_own;
            if (mask[1] && lfsr[4]) pin_nbr = ~pin_nbr;
            if (mask[2] && lfsr[7]) trig_in = ~trig_in;
            if (rnd_ref) ref_wave = lfsr[9];
            flag_clr = rnd_clr && (lfsr[12:10] == 3'b000);
        end
        @(negedge clk);
        flag_clr = 1'b0;
        cnt_val = cnt_val + 1'b1;
    endtask

    task automatic setcfg(logic en, logic [1:0] d, logic [1:0] e, logic [1:0] p, logic t);
        @(negedge clk);
        cfg_en = en; cfg_dir = d; cfg_edge = e; cfg_psc = p; trig_sel_ok = t;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_val = cnt_val + 1'b1;
        end
    endtask

    task automatic own_rises(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin_own = 1'b1; idle(4);
            @(negedge clk); pin_own = 1'b0; idle(4);
        end
    endtask

    task automatic expect_count(string t, int exp);
        idle(6);
        total++;
        if (stb_seen != exp) begin
            bad++;
            $display("FAIL %s: got %0d strobes expected %0d", t, stb_seen, exp);
        end
        stb_seen = 0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11 cap_stb", CW'(cap_stb), '0);
        check("R11 cap_flag", CW'(cap_flag), '0);
        check("R11 ovr_flag", CW'(ovr_flag), '0);
        check("R11 cap_val", cap_val, '0);
        check("R11 pin_out", CW'(pin_out), '0);
        check("R11 ch_trig", CW'(ch_trig), '0);
        rst_n = 1'b1;
        chk_on = 1;

        setcfg(1, 2'b01, 2'b00, 2'b00, 0); run("R1 R5 own rising", 300, 3'b111, 0, 1);
        setcfg(1, 2'b10, 2'b01, 2'b00, 0); run("R1 R5 R9 nbr falling", 300, 3'b111, 0, 1);
        setcfg(1, 2'b11, 2'b11, 2'b00, 1); run("R1 R5 trig both", 300, 3'b111, 0, 1);
        setcfg(1, 2'b01, 2'b11, 2'b01, 0); run("R3 div2", 300, 3'b111, 0, 1);
        setcfg(1, 2'b01, 2'b11, 2'b10, 0); run("R3 div4", 300, 3'b111, 0, 1);
        setcfg(1, 2'b10, 2'b11, 2'b11, 0); run("R3 div8", 400, 3'b111, 0, 1);
        setcfg(1, 2'b01, 2'b00, 2'b00, 0); run("R7 no clear", 200, 3'b001, 0, 0);
        setcfg(1, 2'b00, 2'b00, 2'b00, 0); run("R8 out high", 200, 3'b111, 1, 1);
        setcfg(1, 2'b00, 2'b01, 2'b00, 0); run("R8 out low", 200, 3'b111, 1, 1);
        setcfg(0, 2'b00, 2'b01, 2'b00, 0); run("R8 out off", 100, 3'b111, 1, 1);

        idle(6); stb_seen = 0;
        setcfg(1, 2'b01, 2'b10, 2'b00, 0); run("R2 reserved edge", 200, 3'b111, 0, 1);
        expect_count("R2 reserved edge strobes", 0);
        setcfg(1, 2'b11, 2'b11, 2'b00, 0); run("R2 trig unselected", 200, 3'b111, 0, 1);
        expect_count("R2 trig unselected strobes", 0);
        setcfg(0, 2'b01, 2'b11, 2'b00, 0); run("R10 disabled", 200, 3'b111, 0, 1);
        expect_count("R10 disabled strobes", 0);

        // R4: clear on disable, ratio change without clear
        setcfg(1, 2'b01, 2'b00, 2'b11, 0); idle(4); stb_seen = 0;
        tag = "R4 clear on disable";
        own_rises(5);
        expect_count("R4 five of eight", 0);
        setcfg(0, 2'b01, 2'b00, 2'b11, 0); idle(4);
        setcfg(1, 2'b01, 2'b00, 2'b11, 0); idle(4);
        own_rises(7);
        expect_count("R4 count restarted", 0);
        own_rises(1);
        expect_count("R4 eighth edge", 1);
        tag = "R4 ratio change";
        own_rises(5);
        expect_count("R4 five before change", 0);
        setcfg(1, 2'b01, 2'b00, 2'b01, 0); idle(4);
        own_rises(1);
        expect_count("R4 change keeps count", 1);

        setcfg(1, 2'b10, 2'b00, 2'b10, 0); run("R4 live changes", 100, 3'b111, 0, 1);
        setcfg(1, 2'b10, 2'b00, 2'b00, 0); run("R4 live changes", 100, 3'b111, 0, 1);

        idle(4);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R6 watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

endmodule